// File: doc/BRIEF.md
# Sparsified Binary Pixel Group Readout

This block reads out one group of binary-hit pixels without any trigger and without dead time. Every pixel keeps two small saturating hit counters. One counts hits in the current time slice while the other holds the total of the slice just ended. A single boundary pulse swaps the two roles in every pixel at once, so the pixels keep counting while the frozen totals are read out.

A binary OR tree over the per-pixel "has hits" flags finds the next pixel to read. The search walks from the root to a leaf, always taking the lower-address half when that half holds a hit, so every address costs the same number of cycles wherever the pixel sits. Each hit pixel is sent once, as one serial word carrying its address and its frozen count, and its flag then clears. Empty pixels are never sent. When the tree is empty, an end-of-slice marker word closes the readout.

With the default configuration of 256 pixels and 5-bit counters, sixteen instances serve a 64 x 64 array, one instance per serial line.

Top module: `pxr_group_readout`

## Requirements
- R1: After reset the serial line is low and stays low until the first slice boundary has been sampled. Both counters of every pixel start at zero.
- R2: On the clock edge that samples `slice_i`, every pixel swaps the roles of its two counters. The newly active counter restarts from zero, and a hit present in that same cycle is counted in the new slice.
- R3: Hits that arrive while a readout is in progress are counted for the next slice. No hit is lost to readout activity.
- R4: An active counter stops at 31 (all ones for CNT_W = 5) and does not wrap.
- R5: Only pixels with a nonzero frozen count are sent. Each is sent exactly once per slice, with its frozen count.
- R6: Hit pixels are sent in ascending address order.
- R7: A word is 14 bits, most significant first: a start bit of 1, then the 8-bit pixel address, then the 5-bit count. The line is 0 between words.
- R8: After the last hit pixel of a slice, a marker word is sent: start bit 1, address 255 (all ones), count 0. The line then stays low until the next boundary.
- R9: The address search takes a fixed ADDR_W cycles. The first start bit of a slice appears ADDR_W+1 edges after the boundary edge. Consecutive address words are separated by exactly ADDR_W+1 low cycles. The marker follows the last word after 2 low cycles, or starts 2 edges after the boundary edge when the slice had no hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slice_i | input | 1 | Time-slice boundary pulse, one cycle |
| hit_i | input | N_PIX | Per-pixel hit strobe, one count per cycle high |
| ser_o | output | 1 | Serial output line |

## Verification
A wrong tree decision sends an address out of order or sends an empty pixel, and that shows in the very next word. A stale or mis-swapped counter bank shows as a wrong count field in the next slice's readout, one slice period later. A lost or repeated flag clear shows as a missing or doubled word before that slice's marker. A search that takes the wrong number of steps changes the low gap ahead of the next start bit.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_SEARCH = 2'd1,
    RD_LOAD   = 2'd2,
    RD_SHIFT  = 2'd3
  } rd_state_e;

  // saturating increment; ceiling is the all-ones value of the counter
  function automatic int unsigned sat_step(int unsigned v, int unsigned ceil_v);
    return (v >= ceil_v) ? v : v + 1;
  endfunction

endpackage

// File: rtl/pxr_pixel.sv
module pxr_pixel #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             swap_i,
  input  logic             act_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] frz_cnt_o,
  output logic             pend_o
);
  import pxr_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] bank_q [2];
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q[0] <= '0;
      bank_q[1] <= '0;
      pend_q    <= 1'b0;
    end else if (swap_i) begin
      // idle counter becomes active; a hit in this cycle opens the new slice
      bank_q[~act_i] <= hit_i ? CNT_W'(1) : '0;
      pend_q         <= (bank_q[act_i] != '0);
    end else begin
      if (hit_i)
        bank_q[act_i] <= CNT_W'(sat_step(32'(bank_q[act_i]), CNT_MAX));
      if (rd_clr_i)
        pend_q <= 1'b0;
    end
  end

  assign frz_cnt_o = bank_q[~act_i];
  assign pend_o    = pend_q;

endmodule

// File: rtl/pxr_hit_tree.sv
module pxr_hit_tree #(
  parameter int N_LEAF = 256,
  localparam int ADDR_W = $clog2(N_LEAF)
) (
  input  logic [N_LEAF-1:0] pend_i,
  input  logic [ADDR_W-1:0] node_i,
  output logic              root_o,
  output logic              left_o
);
  // heap layout: node k has children 2k and 2k+1, leaf of pixel p is N_LEAF+p
  logic [2*N_LEAF-1:1] tree;
  logic [ADDR_W:0]     left_idx;

  for (genvar p = 0; p < N_LEAF; p++) begin : g_leaf
    assign tree[N_LEAF+p] = pend_i[p];
  end

  for (genvar k = 1; k < N_LEAF; k++) begin : g_node
    assign tree[k] = tree[2*k] | tree[2*k+1];
  end

  assign left_idx = {node_i, 1'b0};
  assign root_o   = tree[1];
  assign left_o   = tree[left_idx];

endmodule

// File: rtl/pxr_word_ser.sv
module pxr_word_ser #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              last_o
);
  localparam int LEFT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= word_i;
      left_q <= LEFT_W'(WORD_W);
    end else if (left_q != '0) begin
      sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
      left_q <= left_q - LEFT_W'(1);
    end
  end

  assign ser_o  = (left_q != '0) && sr_q[WORD_W-1];
  assign last_o = (left_q == LEFT_W'(1));

endmodule

// File: rtl/pxr_group_readout.sv
module pxr_group_readout #(
  parameter int N_PIX = 256,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_i,
  input  logic [N_PIX-1:0] hit_i,
  output logic             ser_o
);
  import pxr_pkg::*;

  localparam int ADDR_W = $clog2(N_PIX);
  localparam int WORD_W = 1 + ADDR_W + CNT_W;

  // one tree step: append the branch bit to the heap index
  function automatic logic [ADDR_W:0] next_node(logic [ADDR_W-1:0] node, logic left_hit);
    return {node, ~left_hit};
  endfunction

  rd_state_e        state_q;
  logic             act_q;
  logic [ADDR_W:0]  node_q;

  logic [N_PIX-1:0] pend;
  logic [CNT_W-1:0] frz [N_PIX];

  // named internal events
  logic              root_any;
  logic              left_set;
  logic [ADDR_W:0]   node_nx;
  logic              mark_hit;
  logic              srch_step;
  logic              word_load;
  logic              is_mark;
  logic              ser_last;
  logic [ADDR_W-1:0] leaf_addr;
  logic              leaf_pend;
  logic [CNT_W-1:0]  leaf_cnt;
  logic [WORD_W-1:0] ld_word;

  for (genvar p = 0; p < N_PIX; p++) begin : g_pix
    pxr_pixel #(.CNT_W(CNT_W)) u_pix (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (hit_i[p]),
      .swap_i   (slice_i),
      .act_i    (act_q),
      .rd_clr_i (word_load && !is_mark && (leaf_addr == ADDR_W'(p))),
      .frz_cnt_o(frz[p]),
      .pend_o   (pend[p])
    );
  end

  pxr_hit_tree #(.N_LEAF(N_PIX)) u_tree (
    .pend_i(pend),
    .node_i(node_q[ADDR_W-1:0]),
    .root_o(root_any),
    .left_o(left_set)
  );

  assign node_nx   = next_node(node_q[ADDR_W-1:0], left_set);
  assign mark_hit  = (state_q == RD_SEARCH) && (node_q == (ADDR_W+1)'(1)) && !root_any;
  assign srch_step = (state_q == RD_SEARCH) && !mark_hit;
  assign word_load = (state_q == RD_LOAD);
  assign is_mark   = !node_q[ADDR_W];
  assign leaf_addr = node_q[ADDR_W-1:0];
  assign leaf_pend = pend[leaf_addr];
  assign leaf_cnt  = frz[leaf_addr];
  assign ld_word   = is_mark ? {1'b1, {ADDR_W{1'b1}}, {CNT_W{1'b0}}}
                             : {1'b1, leaf_addr, leaf_cnt};

  pxr_word_ser #(.WORD_W(WORD_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(word_load),
    .word_i(ld_word),
    .ser_o (ser_o),
    .last_o(ser_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      act_q   <= 1'b0;
      node_q  <= (ADDR_W+1)'(1);
    end else if (slice_i) begin
      act_q   <= ~act_q;
      state_q <= RD_SEARCH;
      node_q  <= (ADDR_W+1)'(1);
    end else begin
      unique case (state_q)
        RD_IDLE: ;
        RD_SEARCH: begin
          if (mark_hit) begin
            state_q <= RD_LOAD;
          end else begin
            node_q <= node_nx;
            if (node_nx[ADDR_W]) state_q <= RD_LOAD;
          end
        end
        RD_LOAD: state_q <= RD_SHIFT;
        RD_SHIFT: begin
          if (ser_last) begin
            if (is_mark) begin
              state_q <= RD_IDLE;
            end else begin
              state_q <= RD_SEARCH;
              node_q  <= (ADDR_W+1)'(1);
            end
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pxr_readout_chk.sv
module pxr_readout_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slice_i,
  input logic                ser_o,
  input pxr_pkg::rd_state_e  state_q,
  input logic                root_any,
  input logic                srch_step,
  input logic                word_load,
  input logic                is_mark,
  input logic                leaf_pend,
  input logic [CNT_W-1:0]    leaf_cnt
);
  import pxr_pkg::*;

  localparam int SC_W = $clog2(ADDR_W + 2) + 1;
  logic [SC_W-1:0] step_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          step_run <= '0;
    else if (slice_i)    step_run <= '0;
    else if (srch_step)  step_run <= step_run + SC_W'(1);
    else if (word_load)  step_run <= '0;
  end

  // R2
  slice_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_i |=> (state_q == RD_SEARCH));

  // R5
  sparse_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && !is_mark) |-> (leaf_pend && (leaf_cnt != '0)));

  // R7
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && !slice_i) |=> ser_o);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_IDLE) |-> !ser_o);

  // R8
  marker_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && is_mark) |-> !root_any);

  // R9
  search_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && !is_mark) |-> (step_run == SC_W'(ADDR_W)));

endmodule

bind pxr_group_readout pxr_readout_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slice_i  (slice_i),
  .ser_o    (ser_o),
  .state_q  (state_q),
  .root_any (root_any),
  .srch_step(srch_step),
  .word_load(word_load),
  .is_mark  (is_mark),
  .leaf_pend(leaf_pend),
  .leaf_cnt (leaf_cnt)
);

// File: tb/tb_pxr_group_readout.sv
module tb_pxr_group_readout;
  localparam int N         = 256;
  localparam int AW        = 8;
  localparam int CMAX      = 31;
  localparam int SLICE_LEN = 6200;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         slice_i;
  logic [N-1:0] hit_i;
  logic         ser_o;

  int  act_m [N];
  int  frz_m [N];
  int  vec_cnt = 0;
  int  err_cnt = 0;
  bit  finished = 0;

  // monitor state
  bit  armed = 0, rd_done = 0, in_word = 0, first = 0;
  int  ptr = 0, since = 0, low_run = 0, nb = 0;
  logic [12:0] sh;

  always #4 clk = ~clk;

  pxr_group_readout #(.N_PIX(N), .CNT_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .slice_i(slice_i), .hit_i(hit_i), .ser_o(ser_o)
  );

  task automatic chk(bit ok, string req, int got, int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // hits per pixel in each slice; values above 31 exercise saturation (R4)
  function automatic int pat_count(int s, int p);
    case (s)
      0: return (p % 5 == 0) ? 0 : (p * 7 + 3) % 37;
      1: return (p % 31) + 1;
      2: return (p == 255) ? 1 : 0;
      3: return (p == 0) ? 40 : ((p == 128) ? 2 : 0);
      5: return (p == 3 || p == 250) ? CMAX : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int next_nz(int from);
    for (int p = from; p < N; p++) if (frz_m[p] != 0) return p;
    return N;
  endfunction

  // one input cycle; a boundary cycle also carries the first hits of the new slice (R2)
  task automatic drive_cycle(bit sl, int s, int t);
    @(posedge clk);
    #1;
    slice_i = sl;
    if (sl) begin
      for (int p = 0; p < N; p++) begin
        frz_m[p] = act_m[p];
        act_m[p] = 0;
      end
    end
    if (t < 40) begin
      for (int p = 0; p < N; p++) begin
        hit_i[p] = (t < pat_count(s, p));
        if (hit_i[p]) act_m[p] = (act_m[p] >= CMAX) ? CMAX : act_m[p] + 1;
      end
    end else begin
      hit_i = '0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!slice_i) since++;
      if (in_word) begin
        sh = {sh[11:0], ser_o};
        nb++;
        if (nb == 13) begin
          int nxt;
          in_word = 0;
          nxt = next_nz(ptr);
          if (nxt < N) begin
            chk(int'(sh[12:5]) == nxt, "R6 R7 address", int'(sh[12:5]), nxt);
            chk(int'(sh[4:0]) == frz_m[nxt],
                (frz_m[nxt] == CMAX) ? "R4 saturated count" : "R2 R3 R5 count",
                int'(sh[4:0]), frz_m[nxt]);
            ptr = nxt + 1;
          end else begin
            chk(sh == 13'h1FE0, "R8 marker", int'(sh), 13'h1FE0);
            rd_done = 1;
          end
        end
      end else if (ser_o) begin
        if (!armed) chk(0, "R1 early word", 1, 0);
        else if (rd_done) chk(0, "R8 word after marker", 1, 0);
        else begin
          int nxt;
          nxt = next_nz(ptr);
          if (first) chk(since == ((nxt < N) ? AW + 2 : 3), "R9 first start", since, (nxt < N) ? AW + 2 : 3);
          else       chk(low_run == ((nxt < N) ? AW + 1 : 2), "R9 gap", low_run, (nxt < N) ? AW + 1 : 2);
        end
        in_word = 1; nb = 0; sh = '0; low_run = 0; first = 0;
      end else begin
        low_run++;
      end
      if (slice_i) begin
        if (armed) chk(rd_done, "R8 readout closed", int'(rd_done), 1);
        armed = 1; rd_done = 0; ptr = 0; since = 0; first = 1; low_run = 0;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      chk(0, "R9 watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < N; p++) begin act_m[p] = 0; frz_m[p] = 0; end
    rst_n = 1'b0; slice_i = 1'b0; hit_i = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: line quiet after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ser_o == 1'b0, "R1 reset line", int'(ser_o), 0);
    end
    for (int t = 0; t < SLICE_LEN; t++) drive_cycle(1'b0, 0, t);
    // R3: each slice is counted while the previous one is read out
    for (int k = 0; k < 7; k++)
      for (int t = 0; t < SLICE_LEN; t++) drive_cycle(t == 0, k + 1, t);
    @(negedge clk);
    chk(rd_done, "R8 final marker", int'(rd_done), 1);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule